// File: doc/BRIEF.md
# Two-Speed Start-Up Clock Switcher

This block chooses where the system clock comes from after a reset, after power-on, or on wake from sleep. When the primary oscillator is a crystal type and the fast-start option is enabled, the system starts running at once from the always-on internal RC clock. Meanwhile, a start-up timer counts cycles of the primary oscillator. When the timer expires, the block raises a status flag on a falling edge of the RC clock. It then holds the system clock low for eight falling edges of the primary clock and hands the system over to the primary clock. The hand-over has no glitches.

Software controls the choice through a two-bit select register. A non-zero value keeps the system on the RC clock, so code can run briefly and go back to sleep without waiting for the crystal to settle. A non-zero value also sends a running system back to the RC clock. A sleep request stops the system clock and aborts any start-up in progress. With the fast-start option off, the system clock stays low until the crystal is counted stable. With a non-crystal primary mode, the start-up count is skipped.

Top module: `tss_startup`

## Requirements
- R1: After reset, `src_o` is 00 (none), `osts_o` is 0 and `sys_clk_o` stays low. No start-up begins while `por_done_i` is low.
- R2: With a crystal mode (`prim_mode_i` 00, 01 or 10) and `two_speed_en_i` high, a start-up starts when `por_done_i` rises after reset or when `wake_i` is seen in sleep. `src_o` then becomes 01 (internal RC) and `sys_clk_o` follows the RC clock.
- R3: Each start-up counts at least 1024 primary-clock cycles, starting again from zero, before `osts_o` may rise.
- R4: `osts_o` changes only on a falling edge of the internal RC clock.
- R5: After `osts_o` rises with select 00, `sys_clk_o` is held low for at least eight falling edges of the primary clock. It then follows the primary clock, and `src_o` becomes 10.
- R6: No high pulse on `sys_clk_o` is shorter than the shorter high phase of the two source clocks, and both sources are never gated through together.
- R7: Primary mode 11 (non-crystal) skips the start-up count. `osts_o` rises within a few RC cycles and the primary clock is selected.
- R8: With `two_speed_en_i` low in a crystal mode, `sys_clk_o` stays low and `src_o` stays 00 until `osts_o` rises. The hand-over of R5 follows.
- R9: A sleep request makes `src_o` 00, clears `osts_o`, and stops `sys_clk_o`. A start-up aborted by sleep leaves `osts_o` clear.
- R10: While the select register holds a non-zero value, the block stays on the RC clock even after the count expires, with `osts_o` set. Writing 00 then hands over to the primary clock.
- R11: Writing a non-zero select value while on the primary clock returns the system to the RC clock (`src_o` 01).
- R12: Reset returns the select register to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| intrc_clk_i | input | 1 | Always-on internal RC clock |
| prim_clk_i | input | 1 | Primary oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| por_done_i | input | 1 | Power-up timer expired after power-on |
| wake_i | input | 1 | Wake event while asleep |
| sleep_i | input | 1 | Sleep request |
| two_speed_en_i | input | 1 | Enables running from the RC clock during start-up |
| prim_mode_i | input | 2 | Primary mode: 00, 01, 10 crystal types, 11 non-crystal |
| scs_i | input | 2 | Software clock-select write data |
| scs_we_i | input | 1 | Write strobe for the select register (level, held several RC cycles) |
| sys_clk_o | output | 1 | Gated system clock |
| osts_o | output | 1 | Start-up status: primary counted stable |
| src_o | output | 2 | Current source: 00 none, 01 internal RC, 10 primary |

## Verification
The bench measures, in primary-clock edges, the interval from the start of a start-up to the rise of the status flag. A timer that does not clear between start-ups would finish early. The bench also counts how many primary falling edges pass with the system clock held low at the hand-over, and it tracks the narrowest high pulse on the system clock. A design with a short hold or with enables that overlap fails these checks. A sleep request in the middle of a count, a select value that blocks the hand-over, and a reset that should clear that select value are each driven. A design that ignores any of them stays on the wrong source or raises the flag when it should not.

// File: rtl/tss_pkg.sv
package tss_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_INT  = 2'b01,
    SRC_PRI  = 2'b10
  } src_e;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_SLEEP,
    ST_INT,
    ST_WAIT,
    ST_HOLD,
    ST_PRI,
    ST_REL
  } state_e;

  localparam logic [1:0] MODE_EXT = 2'b11;

  function automatic logic is_xtal(input logic [1:0] mode);
    return mode != MODE_EXT;
  endfunction
endpackage

// File: rtl/tss_sync.sv
// Multi-stage synchronizer; flops capture on the falling edge of clk_i.
module tss_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/tss_prim_ctrl.sv
// Primary-domain logic: start-up timer and hand-over hold counter.
module tss_prim_ctrl #(
  parameter int OST_CYCLES  = 1024,
  parameter int HOLD_EDGES  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic prim_clk_i,
  input  logic rst_ni,
  input  logic ost_req_i,
  input  logic hold_req_i,
  output logic ost_done_o,
  output logic pri_en_o
);
  localparam int OST_W  = $clog2(OST_CYCLES + 1);
  localparam int HOLD_W = $clog2(HOLD_EDGES + 1);

  logic             ost_req_s, hold_req_s;
  logic [OST_W-1:0] ost_cnt_q;
  logic             ost_done_q;
  logic [HOLD_W-1:0] hold_cnt_q;
  logic             pri_en_q;

  tss_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_req_sync (
    .clk_i (prim_clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ost_req_i, hold_req_i}),
    .q_o   ({ost_req_s, hold_req_s})
  );

  // Counter restarts from zero whenever the request drops.
  always_ff @(negedge prim_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ost_cnt_q  <= '0;
      ost_done_q <= 1'b0;
    end else if (!ost_req_s) begin
      ost_cnt_q  <= '0;
      ost_done_q <= 1'b0;
    end else if (!ost_done_q) begin
      ost_cnt_q <= ost_cnt_q + OST_W'(1);
      if (ost_cnt_q == OST_W'(OST_CYCLES - 1)) ost_done_q <= 1'b1;
    end
  end

  // Enable changes on a falling edge, i.e. while the primary clock is low.
  always_ff @(negedge prim_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_cnt_q <= '0;
      pri_en_q   <= 1'b0;
    end else if (!hold_req_s) begin
      hold_cnt_q <= '0;
      pri_en_q   <= 1'b0;
    end else if (!pri_en_q) begin
      hold_cnt_q <= hold_cnt_q + HOLD_W'(1);
      if (hold_cnt_q == HOLD_W'(HOLD_EDGES - 1)) pri_en_q <= 1'b1;
    end
  end

  assign ost_done_o = ost_done_q;
  assign pri_en_o   = pri_en_q;
endmodule

// File: rtl/tss_ctrl.sv
// Sequencer in the internal RC domain, clocked on its falling edge.
module tss_ctrl
  import tss_pkg::*;
(
  input  logic       intrc_clk_i,
  input  logic       rst_ni,
  input  logic       por_s_i,
  input  logic       wake_s_i,
  input  logic       sleep_s_i,
  input  logic       scs_we_s_i,
  input  logic       ost_done_s_i,
  input  logic       pri_on_s_i,
  input  logic [1:0] scs_i,
  input  logic       two_speed_en_i,
  input  logic [1:0] prim_mode_i,
  output logic       int_en_o,
  output logic       ost_req_o,
  output logic       hold_req_o,
  output logic       osts_o,
  output logic [1:0] src_o,
  output logic [1:0] scs_o
);
  state_e     state_q, nxt, start_st;
  logic       xtal, quiet;
  logic       int_en_q, ost_req_q, hold_req_q, osts_q, osts_d;
  logic [1:0] src_q, scs_q;

  assign xtal     = is_xtal(prim_mode_i);
  // Primary side must have dropped old state before a new start.
  assign quiet    = !ost_done_s_i && !pri_on_s_i;
  assign start_st = !xtal ? ST_HOLD : (two_speed_en_i ? ST_INT : ST_WAIT);

  always_comb begin
    nxt = state_q;
    unique case (state_q)
      ST_BOOT:  if (por_s_i && quiet) nxt = start_st;
      ST_SLEEP: if (wake_s_i && quiet) nxt = start_st;
      ST_INT: begin
        if (sleep_s_i) nxt = ST_SLEEP;
        else if (ost_done_s_i && scs_q == 2'b00) nxt = ST_HOLD;
      end
      ST_WAIT: begin
        if (sleep_s_i) nxt = ST_SLEEP;
        else if (ost_done_s_i) nxt = ST_HOLD;
      end
      ST_HOLD: begin
        if (sleep_s_i) nxt = ST_SLEEP;
        else if (pri_on_s_i) nxt = ST_PRI;
      end
      ST_PRI: begin
        if (sleep_s_i) nxt = ST_SLEEP;
        else if (scs_q != 2'b00) nxt = ST_REL;
      end
      ST_REL: begin
        if (sleep_s_i) nxt = ST_SLEEP;
        else if (!pri_on_s_i) nxt = ST_INT;
      end
      default: nxt = ST_BOOT;
    endcase
  end

  always_comb begin
    if (nxt == ST_BOOT || nxt == ST_SLEEP) osts_d = 1'b0;
    else osts_d = osts_q || (nxt == ST_HOLD) ||
                  (nxt == ST_INT && ost_done_s_i && xtal);
  end

  // All outputs registered so gate enables and request lines are glitch-free.
  always_ff @(negedge intrc_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_BOOT;
      int_en_q   <= 1'b0;
      ost_req_q  <= 1'b0;
      hold_req_q <= 1'b0;
      osts_q     <= 1'b0;
      src_q      <= SRC_NONE;
      scs_q      <= 2'b00;
    end else begin
      state_q    <= nxt;
      int_en_q   <= (nxt == ST_INT);
      ost_req_q  <= xtal && !(nxt inside {ST_BOOT, ST_SLEEP});
      hold_req_q <= (nxt inside {ST_HOLD, ST_PRI});
      osts_q     <= osts_d;
      src_q      <= (nxt == ST_INT) ? SRC_INT : (nxt == ST_PRI) ? SRC_PRI : SRC_NONE;
      if (scs_we_s_i) scs_q <= scs_i;
    end
  end

  assign int_en_o   = int_en_q;
  assign ost_req_o  = ost_req_q;
  assign hold_req_o = hold_req_q;
  assign osts_o     = osts_q;
  assign src_o      = src_q;
  assign scs_o      = scs_q;
endmodule

// File: rtl/tss_clk_mux.sv
// AND-OR clock combiner; each enable moves only while its clock is low.
module tss_clk_mux #(
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0] clk_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic               clk_o
);
  assign clk_o = |(clk_i & en_i);
endmodule

// File: rtl/tss_startup.sv
module tss_startup
  import tss_pkg::*;
#(
  parameter int OST_CYCLES  = 1024,
  parameter int HOLD_EDGES  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       intrc_clk_i,
  input  logic       prim_clk_i,
  input  logic       rst_ni,
  input  logic       por_done_i,
  input  logic       wake_i,
  input  logic       sleep_i,
  input  logic       two_speed_en_i,
  input  logic [1:0] prim_mode_i,
  input  logic [1:0] scs_i,
  input  logic       scs_we_i,
  output logic       sys_clk_o,
  output logic       osts_o,
  output logic [1:0] src_o
);
  localparam int N_INT_SYNC = 6;

  logic por_s, wake_s, sleep_s, scs_we_s, ost_done_s, pri_on_s;
  logic int_en, pri_en, ost_req, hold_req, ost_done;
  logic [1:0] scs_q;

  tss_sync #(.WIDTH(N_INT_SYNC), .STAGES(SYNC_STAGES)) i_int_sync (
    .clk_i (intrc_clk_i),
    .rst_ni(rst_ni),
    .d_i   ({por_done_i, wake_i, sleep_i, scs_we_i, ost_done, pri_en}),
    .q_o   ({por_s, wake_s, sleep_s, scs_we_s, ost_done_s, pri_on_s})
  );

  tss_prim_ctrl #(
    .OST_CYCLES (OST_CYCLES),
    .HOLD_EDGES (HOLD_EDGES),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_prim_ctrl (
    .prim_clk_i(prim_clk_i),
    .rst_ni    (rst_ni),
    .ost_req_i (ost_req),
    .hold_req_i(hold_req),
    .ost_done_o(ost_done),
    .pri_en_o  (pri_en)
  );

  tss_ctrl i_ctrl (
    .intrc_clk_i   (intrc_clk_i),
    .rst_ni        (rst_ni),
    .por_s_i       (por_s),
    .wake_s_i      (wake_s),
    .sleep_s_i     (sleep_s),
    .scs_we_s_i    (scs_we_s),
    .ost_done_s_i  (ost_done_s),
    .pri_on_s_i    (pri_on_s),
    .scs_i         (scs_i),
    .two_speed_en_i(two_speed_en_i),
    .prim_mode_i   (prim_mode_i),
    .int_en_o      (int_en),
    .ost_req_o     (ost_req),
    .hold_req_o    (hold_req),
    .osts_o        (osts_o),
    .src_o         (src_o),
    .scs_o         (scs_q)
  );

  tss_clk_mux #(.NUM_SRC(2)) i_clk_mux (
    .clk_i({prim_clk_i, intrc_clk_i}),
    .en_i ({pri_en, int_en}),
    .clk_o(sys_clk_o)
  );
endmodule

// File: rtl/tss_startup_chk.sv
module tss_startup_chk
  import tss_pkg::*;
(
  input logic       intrc_clk_i,
  input logic       rst_ni,
  input logic       two_speed_en_i,
  input logic [1:0] prim_mode_i,
  input logic       osts_o,
  input logic [1:0] src_o,
  input logic       int_en,
  input logic       pri_en,
  input logic       ost_req,
  input logic       ost_done_s,
  input logic [1:0] scs_q
);
  // R6
  gate_excl_chk: assert property (@(negedge intrc_clk_i) disable iff (!rst_ni)
    !(int_en && pri_en));

  // R3
  osts_after_count_chk: assert property (@(negedge intrc_clk_i) disable iff (!rst_ni)
    ($rose(osts_o) && is_xtal(prim_mode_i)) |-> ost_done_s);

  // R5
  pri_needs_osts_chk: assert property (@(negedge intrc_clk_i) disable iff (!rst_ni)
    (src_o == SRC_PRI) |-> osts_o);

  // R7
  ext_no_count_chk: assert property (@(negedge intrc_clk_i) disable iff (!rst_ni)
    !is_xtal(prim_mode_i) |-> !ost_req);

  // R8
  slow_start_no_int_chk: assert property (@(negedge intrc_clk_i) disable iff (!rst_ni)
    (!two_speed_en_i && is_xtal(prim_mode_i) && !osts_o) |-> (src_o != SRC_INT));

  // R10
  scs_blocks_pri_chk: assert property (@(negedge intrc_clk_i) disable iff (!rst_ni)
    (scs_q != 2'b00 && src_o == SRC_INT) |=> (src_o != SRC_PRI));
endmodule

bind tss_startup tss_startup_chk i_tss_startup_chk (
  .intrc_clk_i   (intrc_clk_i),
  .rst_ni        (rst_ni),
  .two_speed_en_i(two_speed_en_i),
  .prim_mode_i   (prim_mode_i),
  .osts_o        (osts_o),
  .src_o         (src_o),
  .int_en        (int_en),
  .pri_en        (pri_en),
  .ost_req       (ost_req),
  .ost_done_s    (ost_done_s),
  .scs_q         (scs_q)
);

// File: tb/test_tss_startup.sv
`timescale 1ns/1ps
module test_tss_startup;
  localparam int CLK_PERIOD    = 10;
  localparam int INTRC_PERIOD  = 76;
  localparam int OST_CYCLES    = 1024;
  localparam int HOLD_EDGES    = 8;
  localparam int WATCHDOG_CYC  = 100000;
  localparam int LONG_POLLS    = 1400;

  logic intrc_clk = 1'b0, prim_clk = 1'b0;
  logic rst_ni = 1'b0, por_done = 1'b0, wake = 1'b0, sleep_req = 1'b0;
  logic two_speed_en = 1'b1, scs_we = 1'b0;
  logic [1:0] prim_mode = 2'b01, scs = 2'b00;
  logic sys_clk, osts;
  logic [1:0] src;

  int n_checks = 0, n_errs = 0;
  longint prim_negs = 0, sys_pos = 0, gap = 0, max_gap = 0;
  longint int_start_negs = 0, osts_negs = 0, osts_sys_snap = 0;
  int bad_osts_edge = 0;
  realtime t_rise = 0.0, min_high = 1.0e9;
  bit rise_valid = 1'b0;

  always #(INTRC_PERIOD/2) intrc_clk = ~intrc_clk;
  always #(CLK_PERIOD/2) prim_clk = ~prim_clk;

  tss_startup #(.OST_CYCLES(OST_CYCLES), .HOLD_EDGES(HOLD_EDGES)) i_tss_startup (
    .intrc_clk_i(intrc_clk), .prim_clk_i(prim_clk), .rst_ni(rst_ni),
    .por_done_i(por_done), .wake_i(wake), .sleep_i(sleep_req),
    .two_speed_en_i(two_speed_en), .prim_mode_i(prim_mode),
    .scs_i(scs), .scs_we_i(scs_we),
    .sys_clk_o(sys_clk), .osts_o(osts), .src_o(src)
  );

  // Monitors
  always @(negedge prim_clk) begin
    prim_negs++;
    if (sys_clk == 1'b0) gap++;
  end
  always @(posedge sys_clk) begin
    sys_pos++;
    if (gap > max_gap) max_gap = gap;
    gap = 0;
    t_rise = $realtime;
    rise_valid = 1'b1;
  end
  always @(negedge sys_clk) begin
    if (rise_valid && ($realtime - t_rise) < min_high) min_high = $realtime - t_rise;
  end
  always @(src) if (src == 2'b01) int_start_negs = prim_negs;
  always @(posedge osts) begin
    osts_negs = prim_negs;
    osts_sys_snap = sys_pos;
    if (intrc_clk !== 1'b0) bad_osts_edge++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_src(input logic [1:0] s, input int polls, input string req);
    bit hit = 1'b0;
    for (int i = 0; i < polls && !hit; i++) begin
      if (src === s) hit = 1'b1;
      else #(CLK_PERIOD);
    end
    check(hit, req, "source reached", longint'(src), longint'(s));
  endtask

  task automatic wait_osts(input int polls, input string req);
    bit hit = 1'b0;
    for (int i = 0; i < polls && !hit; i++) begin
      if (osts === 1'b1) hit = 1'b1;
      else #(CLK_PERIOD);
    end
    check(hit, req, "status set", longint'(osts), 1);
  endtask

  task automatic pulse_sleep();
    sleep_req = 1'b1;
    #(30*CLK_PERIOD);
    sleep_req = 1'b0;
  endtask

  task automatic do_wake(input string req);
    wake = 1'b1;
    wait_src(2'b01, 200, req);
    wake = 1'b0;
  endtask

  task automatic write_scs(input logic [1:0] v);
    scs = v;
    scs_we = 1'b1;
    #(30*CLK_PERIOD);
    scs_we = 1'b0;
    #(30*CLK_PERIOD);
  endtask

  task automatic apply_reset(input logic en, input logic [1:0] mode);
    rst_ni = 1'b0;
    por_done = 1'b0;
    two_speed_en = en;
    prim_mode = mode;
    #(20*CLK_PERIOD);
    rst_ni = 1'b1;
    #(CLK_PERIOD);
  endtask

  task automatic count_sys(input int cyc, output longint n);
    longint s0 = sys_pos;
    #(cyc*CLK_PERIOD);
    n = sys_pos - s0;
  endtask

  // R1
  task automatic t_reset();
    longint n;
    check(src == 2'b00, "R1", "src in reset", longint'(src), 0);
    check(osts == 1'b0, "R1", "osts in reset", longint'(osts), 0);
    apply_reset(1'b1, 2'b01);
    count_sys(30*INTRC_PERIOD/CLK_PERIOD, n);
    check(n == 0, "R1", "sys clock idle before por", n, 0);
    check(src == 2'b00, "R1", "no start before por", longint'(src), 0);
  endtask

  // R2 R3 R4 R5 R6
  task automatic t_two_speed();
    longint n;
    max_gap = 0;
    min_high = 1.0e9;
    por_done = 1'b1;
    wait_src(2'b01, 200, "R2");
    count_sys(10*INTRC_PERIOD/CLK_PERIOD*CLK_PERIOD/CLK_PERIOD, n);
    check(n >= 9 && n <= 11, "R2", "sys follows RC", n, 10);
    #(300*CLK_PERIOD);
    check(osts == 1'b0, "R3", "status clear mid count", longint'(osts), 0);
    wait_osts(LONG_POLLS, "R3");
    n = osts_negs - int_start_negs;
    check(n >= OST_CYCLES && n <= OST_CYCLES + 40, "R3", "count length", n, OST_CYCLES);
    check(bad_osts_edge == 0, "R4", "status on RC falling edge", bad_osts_edge, 0);
    max_gap = 0;
    wait_src(2'b10, 200, "R5");
    #(20*CLK_PERIOD);
    check(max_gap >= HOLD_EDGES && max_gap <= HOLD_EDGES + 4, "R5", "low hold edges",
          max_gap, HOLD_EDGES);
    count_sys(20, n);
    check(n >= 19 && n <= 21, "R5", "sys follows primary", n, 20);
    check(min_high >= real'(CLK_PERIOD)/2.0 - 0.1, "R6", "narrowest high pulse x10",
          longint'(min_high*10.0), longint'(CLK_PERIOD*5));
  endtask

  // R9
  task automatic t_sleep_from_pri();
    longint n;
    pulse_sleep();
    wait_src(2'b00, 100, "R9");
    check(osts == 1'b0, "R9", "status cleared by sleep", longint'(osts), 0);
    #(10*CLK_PERIOD);
    count_sys(30, n);
    check(n == 0, "R9", "sys clock stopped", n, 0);
  endtask

  // R2 R9
  task automatic t_abort();
    do_wake("R2");
    #(300*CLK_PERIOD);
    pulse_sleep();
    wait_src(2'b00, 100, "R9");
    #(1500*CLK_PERIOD);
    check(osts == 1'b0, "R9", "aborted status clear", longint'(osts), 0);
    check(src == 2'b00, "R9", "stays asleep", longint'(src), 0);
  endtask

  // R3
  task automatic t_restart();
    longint n;
    do_wake("R3");
    wait_osts(LONG_POLLS, "R3");
    n = osts_negs - int_start_negs;
    check(n >= OST_CYCLES && n <= OST_CYCLES + 40, "R3", "count restarts from zero",
          n, OST_CYCLES);
    wait_src(2'b10, 200, "R5");
  endtask

  // R10
  task automatic t_scs_hold();
    pulse_sleep();
    wait_src(2'b00, 100, "R9");
    #(20*CLK_PERIOD);
    do_wake("R10");
    write_scs(2'b01);
    wait_osts(LONG_POLLS, "R10");
    #(300*CLK_PERIOD);
    check(src == 2'b01, "R10", "held on RC", longint'(src), 1);
    write_scs(2'b00);
    wait_src(2'b10, 200, "R10");
  endtask

  // R11
  task automatic t_scs_back();
    longint n;
    write_scs(2'b10);
    wait_src(2'b01, 200, "R11");
    count_sys(76, n);
    check(n >= 9 && n <= 11, "R11", "back on RC rate", n, 10);
  endtask

  // R12
  task automatic t_reset_scs();
    apply_reset(1'b1, 2'b01);
    por_done = 1'b1;
    wait_src(2'b01, 200, "R12");
    wait_osts(LONG_POLLS, "R12");
    wait_src(2'b10, 200, "R12");
  endtask

  // R8
  task automatic t_no_two_speed();
    longint s0;
    apply_reset(1'b0, 2'b10);
    s0 = sys_pos;
    por_done = 1'b1;
    #(100*CLK_PERIOD);
    check(src == 2'b00, "R8", "no RC run", longint'(src), 0);
    wait_osts(LONG_POLLS, "R8");
    check(osts_sys_snap == s0, "R8", "sys idle until stable", osts_sys_snap - s0, 0);
    wait_src(2'b10, 200, "R8");
  endtask

  // R7
  task automatic t_ext_mode();
    longint n0, n;
    apply_reset(1'b1, 2'b11);
    n0 = prim_negs;
    por_done = 1'b1;
    wait_osts(200, "R7");
    n = osts_negs - n0;
    check(n < 100, "R7", "no start-up count", n, 0);
    wait_src(2'b10, 200, "R7");
  endtask

  initial begin
    #1;
    t_reset();
    t_two_speed();
    t_sleep_from_pri();
    t_abort();
    t_restart();
    t_scs_hold();
    t_scs_back();
    t_reset_scs();
    t_no_two_speed();
    t_ext_mode();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    #(WATCHDOG_CYC*CLK_PERIOD);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule